// File: doc/BRIEF.md
# Prime-Modulus Multiplicative Pseudo-Random Generator

This block produces a pseudo-random sequence of 31-bit integers by the multiplicative congruential rule: next state = 16807 · state mod (2^31 − 1). The product is never formed at full width. The state is split by the constant q = 127773 into a quotient and a remainder. The result is then recombined with the constant r = 2836, so that every intermediate value fits in a 32-bit signed word. When the recombined value is not positive, the modulus is added to it.

A client loads a seed or asks for the next value. Each accepted request divides the state by q with a serial restoring divider, one quotient bit per cycle. One further cycle combines the parts, stores the new state and presents it on a 32-bit output word with a one-cycle valid strobe. The output can be compared directly against 32-bit probability entries. Requests and seed loads are taken only while the block is idle.

Top module: `prng_minstd`

## Requirements
- R1: After reset, `busy` and `rand_valid` are 0, `rand_out` is 0, and the internal state is 1, so the first request yields 16807.
- R2: Each result equals 16807 × (previous state) mod 2147483647, where the previous state is the last result or the last loaded seed.
- R3: The next state is computed as 16807·(I mod 127773) − 2836·floor(I/127773). When this value is zero or negative, 2147483647 is added to it. No intermediate value is wider than 32 signed bits.
- R4: `rand_out` is 32 bits wide. Bit 31 is always 0, and every result lies in 1 to 2147483646.
- R5: `seed_we` in an idle cycle loads `seed_in` as the new state. A seed of 0 or of 2147483647 (all 31 bits set) is replaced by 1.
- R6: When `seed_we` and `next_req` are both high in an idle cycle, the seed is loaded and the request is dropped: `busy` stays 0 and no result appears.
- R7: A request sampled at an idle rising edge E sets `busy` from edge E. It raises `rand_valid` for exactly one cycle after edge E+32, which is W+1 edges later with W = 31. `busy` falls at that same edge.
- R8: `next_req` and `seed_we` have no effect while `busy` is high. The pending result and the state that follows it are unchanged.
- R9: Starting from a state of 1, the first three results are 16807, 282475249 and 1622650073.
- R10: `rand_out` holds its value between `rand_valid` pulses, including across seed loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_we | input | 1 | Load `seed_in` as the state (idle only) |
| seed_in | input | 31 | Seed value |
| next_req | input | 1 | Request the next value (idle only) |
| busy | output | 1 | A request is in progress |
| rand_out | output | 32 | Latest result, bit 31 always 0 |
| rand_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench builds the block with its default parameters: 31-bit state, multiplier 16807, q = 127773 and r = 2836. With these values the known opening sequence from a state of 1 can be checked, and so can the exact 32-edge latency. A seed equal to q drives the recombined value negative, which exercises the add-modulus branch. The seed values 0 and all-ones reach the clamp. A long run of back-to-back requests, checked against a 64-bit reference product, covers both recombination branches many times.

// File: rtl/prng_minstd_pkg.sv
package prng_minstd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DIV  = 2'd1,
        PH_CALC = 2'd2
    } phase_e;

endpackage

// File: rtl/prng_div_step.sv
// One step of a restoring divider by the constant DIVISOR.
module prng_div_step #(
    parameter int W       = 31,
    parameter int RW      = 18,
    parameter int DIVISOR = 127773
) (
    input  logic [W-1:0]  dvd_i,
    input  logic [RW-1:0] rem_i,
    input  logic [W-1:0]  quo_i,
    output logic [W-1:0]  dvd_o,
    output logic [RW-1:0] rem_o,
    output logic [W-1:0]  quo_o
);
    logic [RW-1:0] rem_sh;
    logic          fits;

    always_comb begin
        rem_sh = {rem_i[RW-2:0], dvd_i[W-1]};
        fits   = (rem_sh >= RW'(DIVISOR));
        rem_o  = fits ? (rem_sh - RW'(DIVISOR)) : rem_sh;
        quo_o  = {quo_i[W-2:0], fits};
        dvd_o  = {dvd_i[W-2:0], 1'b0};
    end
endmodule

// File: rtl/prng_schrage_mix.sv
// Recombines quotient and remainder into the next state without a wide product.
module prng_schrage_mix #(
    parameter int W    = 31,
    parameter int RW   = 18,
    parameter int MULT = 16807,
    parameter int RCON = 2836
) (
    input  logic [W-1:0]  hi_i,
    input  logic [RW-1:0] lo_i,
    output logic [W-1:0]  next_o
);
    localparam int PW = W + 1;
    localparam logic [W-1:0] MOD_VEC = '1;

    logic [PW-1:0] prod_lo;
    logic [PW-1:0] prod_hi;
    logic [PW-1:0] diff;
    logic [PW-1:0] wrapped;
    logic          positive;

    always_comb begin
        prod_lo  = PW'(lo_i) * PW'(MULT);
        prod_hi  = PW'(hi_i) * PW'(RCON);
        diff     = prod_lo - prod_hi;
        positive = !diff[PW-1] && (diff != '0);
        wrapped  = diff + {1'b0, MOD_VEC};
        next_o   = positive ? diff[W-1:0] : wrapped[W-1:0];
    end
endmodule

// File: rtl/prng_minstd.sv
module prng_minstd
    import prng_minstd_pkg::*;
#(
    parameter int W    = 31,
    parameter int MULT = 16807,
    parameter int QCON = 127773,
    parameter int RCON = 2836
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed_we,
    input  logic [W-1:0] seed_in,
    input  logic         next_req,
    output logic         busy,
    output logic [W:0]   rand_out,
    output logic         rand_valid
);
    localparam int RW = $clog2(QCON) + 1;
    localparam int CW = $clog2(W + 1);
    localparam logic [W-1:0] MOD_VEC = '1;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [W-1:0]  dvd;
        logic [RW-1:0] rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  state;
        logic [W-1:0]  out;
        logic          valid;
    } regs_t;

    regs_t st_d, st_q;

    logic [W-1:0]  step_dvd;
    logic [RW-1:0] step_rem;
    logic [W-1:0]  step_quo;
    logic [W-1:0]  mix_next;
    logic [W-1:0]  cur_state;

    prng_div_step #(.W(W), .RW(RW), .DIVISOR(QCON)) u_step (
        .dvd_i (st_q.dvd),
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .dvd_o (step_dvd),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    prng_schrage_mix #(.W(W), .RW(RW), .MULT(MULT), .RCON(RCON)) u_mix (
        .hi_i   (st_q.quo),
        .lo_i   (st_q.rem),
        .next_o (mix_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (seed_we) begin
                    st_d.state = ((seed_in == '0) || (seed_in == MOD_VEC))
                                 ? W'(1) : seed_in;
                end else if (next_req) begin
                    st_d.phase = PH_DIV;
                    st_d.cnt   = CW'(W);
                    st_d.dvd   = st_q.state;
                    st_d.rem   = '0;
                    st_d.quo   = '0;
                end
            end
            PH_DIV: begin
                st_d.dvd = step_dvd;
                st_d.rem = step_rem;
                st_d.quo = step_quo;
                st_d.cnt = st_q.cnt - CW'(1);
                if (st_q.cnt == CW'(1)) begin
                    st_d.phase = PH_CALC;
                end
            end
            PH_CALC: begin
                st_d.state = mix_next;
                st_d.out   = mix_next;
                st_d.valid = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.state <= W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_state  = st_q.state;
    assign busy       = (st_q.phase != PH_IDLE);
    assign rand_valid = st_q.valid;
    assign rand_out   = {1'b0, st_q.out};

endmodule

// File: rtl/prng_minstd_chk.sv
module prng_minstd_chk #(
    parameter int W = 31
) (
    input logic         clk,
    input logic         rst_n,
    input logic         seed_we,
    input logic [W-1:0] seed_in,
    input logic         next_req,
    input logic         busy,
    input logic [W:0]   rand_out,
    input logic         rand_valid,
    input logic [W-1:0] cur_state
);
    localparam logic [W-1:0] MOD_VEC = '1;

    p_out_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rand_valid |-> (rand_out[W] == 1'b0 && rand_out != '0 && rand_out[W-1:0] != MOD_VEC));

    p_seed_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && !busy && (seed_in == '0 || seed_in == MOD_VEC)) |=> (cur_state == W'(1)));

    p_seed_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && !busy) |=> !busy);

    p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rand_valid |-> !busy);

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rand_valid |=> !rand_valid);

    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(next_req && !seed_we));

    p_busy_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || rand_valid));

    p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_state) || rand_valid));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rand_valid |-> $stable(rand_out));

endmodule

bind prng_minstd prng_minstd_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_we    (seed_we),
    .seed_in    (seed_in),
    .next_req   (next_req),
    .busy       (busy),
    .rand_out   (rand_out),
    .rand_valid (rand_valid),
    .cur_state  (cur_state)
);

// File: tb/prng_minstd_tb.sv
module prng_minstd_tb;
    localparam int W = 31;
    localparam longint MODV = 64'd2147483647;
    localparam longint AMUL = 64'd16807;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seed_we = 1'b0;
    logic [W-1:0] seed_in = '0;
    logic         next_req = 1'b0;
    logic         busy;
    logic [W:0]   rand_out;
    logic         rand_valid;

    int checks = 0;
    int errors = 0;
    longint model = 1;
    longint expq[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    prng_minstd u_dut (
        .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_in(seed_in),
        .next_req(next_req), .busy(busy), .rand_out(rand_out), .rand_valid(rand_valid)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint clampv(input longint s);
        return (s == 0 || s == MODV) ? 64'd1 : s;
    endfunction

    // monitor: scoreboard pop and compare (R2, R3, R4)
    always @(negedge clk) begin
        if (rst_n && rand_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R8 unexpected result", longint'(rand_out), -1);
            end else begin
                longint e;
                e = expq.pop_front();
                check(longint'(rand_out) == e, "R2/R3 value", longint'(rand_out), e);
                check(rand_out[W] == 1'b0, "R4 bit31", longint'(rand_out[W]), 0);
            end
        end
    end

    // driver: one request, checks R7 latency; poke=1 disturbs while busy (R8)
    task automatic do_req(input bit poke);
        longint e;
        bit lat_ok;
        @(negedge clk);
        e = (AMUL * model) % MODV;
        model = e;
        expq.push_back(e);
        next_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        next_req = 1'b0;
        lat_ok = 1'b1;
        for (int k = 0; k <= W; k++) begin
            if (!busy || rand_valid) lat_ok = 1'b0;
            if (poke && k == 4) begin
                seed_we = 1'b1; seed_in = W'(12345); next_req = 1'b1;
            end else begin
                seed_we = 1'b0; next_req = 1'b0;
            end
            @(negedge clk);
        end
        check(lat_ok && rand_valid && !busy, "R7 latency", longint'(rand_valid), 1);
    endtask

    task automatic load_seed(input longint s, input bit with_req);
        @(negedge clk);
        seed_we = 1'b1;
        seed_in = W'(s);
        next_req = with_req;
        @(posedge clk);
        @(negedge clk);
        seed_we = 1'b0;
        next_req = 1'b0;
        model = clampv(s);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [W:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0 && rand_valid == 1'b0, "R1 idle flags", longint'({busy, rand_valid}), 0);
        check(rand_out == '0, "R1 output", longint'(rand_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 opening sequence from state 1
        do_req(1'b0);
        check(rand_out == 32'd16807, "R9 first", longint'(rand_out), 16807);
        do_req(1'b0);
        check(rand_out == 32'd282475249, "R9 second", longint'(rand_out), 282475249);
        do_req(1'b0);
        check(rand_out == 32'd1622650073, "R9 third", longint'(rand_out), 1622650073);

        // R10 hold across idle cycles and a seed load
        held = rand_out;
        repeat (5) @(negedge clk);
        load_seed(777, 1'b0);
        repeat (3) @(negedge clk);
        check(rand_out == held, "R10 hold", longint'(rand_out), longint'(held));

        // R5 clamp of 0 and all-ones
        load_seed(0, 1'b0);
        do_req(1'b0);
        check(rand_out == 32'd16807, "R5 seed 0", longint'(rand_out), 16807);
        load_seed(MODV, 1'b0);
        do_req(1'b0);
        check(rand_out == 32'd16807, "R5 seed all-ones", longint'(rand_out), 16807);

        // R3 non-positive branch: seed = q gives -2836 + m
        load_seed(127773, 1'b0);
        do_req(1'b0);
        check(rand_out == 32'd2147480811, "R3 wrap branch", longint'(rand_out), 2147480811);
        load_seed(MODV - 1, 1'b0);
        do_req(1'b0);
        check(rand_out == 32'd2147466840, "R3 seed m-1", longint'(rand_out), 2147466840);

        // R6 seed and request together
        held = rand_out;
        load_seed(42, 1'b1);
        check(busy == 1'b0, "R6 no start", longint'(busy), 0);
        repeat (W + 4) @(negedge clk);
        check(rand_out == held && !busy, "R6 no result", longint'(rand_out), longint'(held));
        do_req(1'b0);

        // R8 stimulus while busy is ignored
        do_req(1'b1);
        do_req(1'b0);

        // long run for R2/R4
        load_seed(20240607, 1'b0);
        for (int i = 0; i < 200; i++) do_req(1'b0);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R2 all results seen", longint'(expq.size()), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule